// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block turns parallel words into asynchronous serial frames on one output line. Each character frame has a low start bit, then the data bits with the least significant bit first, then a high stop period. Configuration inputs set the data length (8 or 9 bits) and the stop length (half, one, one and a half or two bits). They also choose whether the top data bit carries an even or odd parity bit in place of the word's own bit. The block can also send two special frames on a pulse request. An idle frame keeps the line high for a whole frame. A break frame drives the line low for the start and data positions and then releases it for the stop period.

Bit timing comes from a programmable clock divider. The divider produces an oversampling tick, and sixteen ticks make one bit. Fractional stop lengths are therefore timed exactly. Words enter on a valid/ready stream. A one-entry holding buffer lets a second word wait while a frame is on the line. That word starts directly after the current stop period. The producer may hold `in_valid` high with its data stable for as long as it likes. A word is taken only on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when the holding buffer is empty. While `in_ready` is low, the data presented is ignored. Configuration is sampled when a frame starts.

Top module: `uart_frame_tx`

## Requirements
- R1: During and directly after reset, `txd` is high, `in_ready` is high and `tx_done` is high.
- R2: A character frame starts with `txd` low for one bit time. The data bits follow, bit 0 first. One bit time is 16 ticks, and a tick occurs every `cfg_div` clock cycles.
- R3: With `cfg_long_word`=0 the frame carries `in_data[7:0]` (8 bits) and `in_data[8]` is not sent. With `cfg_long_word`=1 it carries `in_data[8:0]` (9 bits).
- R4: With `cfg_parity_en`=1 the last data bit (bit 7 for short words, bit 8 for long words) is replaced by a parity bit over the lower data bits. With `cfg_parity_odd`=0 the count of ones in the sent data bits is even. With `cfg_parity_odd`=1 it is odd.
- R5: The stop period is high. Its length is set by `cfg_stop`: 2'b00 gives 16 ticks, 2'b01 gives 8 ticks, 2'b11 gives 24 ticks and 2'b10 gives 32 ticks.
- R6: A word accepted while a frame is in progress waits in the holding buffer. `in_ready` stays low while the buffer is full. A word offered while `in_ready` is low is never sent. The buffered word starts in the clock cycle that ends the previous stop period.
- R7: `tx_done` is low whenever a frame is on the line, a word is buffered, or a special-frame request is pending. It is high only when all of these are empty.
- R8: A pulse on `idle_req` sends an idle frame: `txd` stays high for (1 + data bits) bit times plus the configured stop period.
- R9: A pulse on `break_req` sends a break frame: `txd` is low for (1 + data bits) bit times, then high for the configured stop period.
- R10: When several kinds of work wait at a frame boundary, a break frame goes first, then an idle frame, then the buffered word.
- R11: The word length, parity settings and stop length are sampled at frame start. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 16 | Clock cycles per oversampling tick (0 is treated as 1) |
| cfg_long_word | input | 1 | 0: 8 data bits, 1: 9 data bits |
| cfg_parity_en | input | 1 | Replace the last data bit with parity |
| cfg_parity_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_stop | input | 2 | Stop length code |
| in_valid | input | 1 | Word offered on `in_data` |
| in_ready | output | 1 | Holding buffer empty; word accepted when valid and ready |
| in_data | input | 9 | Word to send |
| idle_req | input | 1 | Pulse: queue an idle frame |
| break_req | input | 1 | Pulse: queue a break frame |
| txd | output | 1 | Serial output line, high when idle |
| tx_done | output | 1 | Nothing pending or on the line |

## Verification
The hardest case to reach is a frame boundary where a buffered word, a pending idle request and a pending break request all compete in the same cycle. This is what tests the ordering and the back-to-back start. The bench reaches it by accepting one word and then filling the buffer with a second word while the first frame is still shifting. It then pulses both special requests before the first stop period ends. It decodes the line level cycle by cycle to confirm the break, then the idle frame, then the buffered word. A second case holds a rejected word on the stream during a full buffer. It then checks that no third frame ever leaves.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    K_DATA  = 2'd0,
    K_IDLE  = 2'd1,
    K_BREAK = 2'd2
  } frame_kind_e;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_BODY = 2'd1,
    PH_STOP = 2'd2
  } frame_phase_e;
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  // a divide value of zero behaves like one
  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || restart || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] out_data
);
  logic wr;

  assign in_ready = !full;
  assign wr       = in_valid && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      out_data <= '0;
    end else begin
      if (wr) begin
        full     <= 1'b1;
        out_data <= in_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

  // R6: a buffered word stays put until the engine takes it
  p_keep_until_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(out_data)));

  // R6: the engine only takes a word that is present
  p_take_only_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_tx_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int WMAX = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            load,
  input  frame_kind_e     kind,
  input  logic [WMAX-1:0] word,
  input  logic            long_w,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic [1:0]      stop_code,
  output logic            txd,
  output logic            busy,
  output logic            frame_end
);
  localparam int SRW = WMAX + 1;
  localparam int STW = $clog2(2 * OVS + 1);
  localparam int BW  = $clog2(SRW + 1);

  frame_phase_e    phase;
  logic [SRW-1:0]  sr;
  logic [BW-1:0]   left;
  logic [STW-1:0]  sub;
  logic [STW-1:0]  stop_len;

  logic [WMAX-1:0] dbits;
  logic [SRW-1:0]  body;
  logic [BW-1:0]   nleft;
  logic [STW-1:0]  stop_t;
  logic            par_s;
  logic            par_l;

  // parity over the bits below the replaced position
  assign par_s = (^word[WMAX-3:0]) ^ par_odd;
  assign par_l = (^word[WMAX-2:0]) ^ par_odd;

  always_comb begin
    dbits = word;
    if (!long_w) dbits[WMAX-1] = 1'b1;
    if (par_en) begin
      if (long_w) dbits[WMAX-1] = par_l;
      else        dbits[WMAX-2] = par_s;
    end
    unique case (kind)
      K_IDLE:  body = '1;
      K_BREAK: body = '0;
      default: body = {dbits, 1'b0};
    endcase
    nleft = long_w ? BW'(WMAX) : BW'(WMAX - 1);
    unique case (stop_code)
      2'b01:   stop_t = STW'(OVS / 2);
      2'b10:   stop_t = STW'(2 * OVS);
      2'b11:   stop_t = STW'(OVS + OVS / 2);
      default: stop_t = STW'(OVS);
    endcase
  end

  assign busy      = (phase != PH_OFF);
  assign frame_end = tick && (phase == PH_STOP) && (sub == stop_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_OFF;
      txd      <= 1'b1;
      sr       <= '1;
      left     <= '0;
      sub      <= '0;
      stop_len <= STW'(OVS);
    end else begin
      if (tick) begin
        unique case (phase)
          PH_BODY: begin
            if (sub == STW'(OVS - 1)) begin
              sub <= '0;
              if (left == '0) begin
                phase <= PH_STOP;
                txd   <= 1'b1;
              end else begin
                txd  <= sr[0];
                sr   <= {1'b1, sr[SRW-1:1]};
                left <= left - 1'b1;
              end
            end else begin
              sub <= sub + 1'b1;
            end
          end
          PH_STOP: begin
            if (frame_end) begin
              phase <= PH_OFF;
              sub   <= '0;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (load) begin
        phase    <= PH_BODY;
        txd      <= body[0];
        sr       <= {1'b1, body[SRW-1:1]};
        left     <= nleft;
        sub      <= '0;
        stop_len <= stop_t;
      end
    end
  end

  // R2: a character frame opens with a low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && kind == K_DATA) |=> !txd);

  // R9: a break frame pulls the line low at once
  p_break_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && kind == K_BREAK) |=> !txd);

  // R8: an idle frame keeps the line high from its first cycle
  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && kind == K_IDLE) |=> txd);

  // R5: the stop period is always high
  p_stop_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STOP) |-> txd);

  // R1: no frame on the line means the line rests high
  p_rest_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OFF) |-> txd);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int WMAX  = 9,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_long_word,
  input  logic             cfg_parity_en,
  input  logic             cfg_parity_odd,
  input  logic [1:0]       cfg_stop,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WMAX-1:0]  in_data,
  input  logic             idle_req,
  input  logic             break_req,
  output logic             txd,
  output logic             tx_done
);
  logic            tick;
  logic            busy;
  logic            frame_end;
  logic            hold_full;
  logic [WMAX-1:0] hold_data;
  logic            pend_idle;
  logic            pend_brk;
  logic            have_work;
  logic            load;
  logic            take;
  frame_kind_e     kind;

  always_comb begin
    if (pend_brk)       kind = K_BREAK;
    else if (pend_idle) kind = K_IDLE;
    else                kind = K_DATA;
  end

  assign have_work = pend_brk || pend_idle || hold_full;
  assign load      = have_work && (!busy || frame_end);
  assign take      = load && (kind == K_DATA);
  assign tx_done   = !busy && !hold_full && !pend_brk && !pend_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_idle <= 1'b0;
      pend_brk  <= 1'b0;
    end else begin
      if (break_req)                      pend_brk <= 1'b1;
      else if (load && kind == K_BREAK)   pend_brk <= 1'b0;
      if (idle_req)                       pend_idle <= 1'b1;
      else if (load && kind == K_IDLE)    pend_idle <= 1'b0;
    end
  end

  uart_tx_hold #(.W(WMAX)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .take     (take),
    .full     (hold_full),
    .out_data (hold_data)
  );

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .restart (load),
    .div     (cfg_div),
    .tick    (tick)
  );

  uart_tx_engine #(.OVS(OVS), .WMAX(WMAX)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (load),
    .kind      (kind),
    .word      (hold_data),
    .long_w    (cfg_long_word),
    .par_en    (cfg_parity_en),
    .par_odd   (cfg_parity_odd),
    .stop_code (cfg_stop),
    .txd       (txd),
    .busy      (busy),
    .frame_end (frame_end)
  );

  // R7: reporting completion implies the line is at rest
  p_done_line_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> txd);

  // R10: a pending break is never passed over by a data frame
  p_break_before_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_brk && load) |-> !take);
endmodule

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_div = 16'd1;
  logic        cfg_long_word = 1'b0;
  logic        cfg_parity_en = 1'b0;
  logic        cfg_parity_odd = 1'b0;
  logic [1:0]  cfg_stop = 2'b00;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [8:0]  in_data = '0;
  logic        idle_req = 1'b0;
  logic        break_req = 1'b0;
  logic        txd;
  logic        tx_done;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_frame_tx i_uart_frame_tx (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_div        (cfg_div),
    .cfg_long_word  (cfg_long_word),
    .cfg_parity_en  (cfg_parity_en),
    .cfg_parity_odd (cfg_parity_odd),
    .cfg_stop       (cfg_stop),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_data        (in_data),
    .idle_req       (idle_req),
    .break_req      (break_req),
    .txd            (txd),
    .tx_done        (tx_done)
  );

  // {data[8:0], long, parity_en, parity_odd, stop[1:0]}
  localparam logic [13:0] VECS [0:7] = '{
    {9'h0A5, 1'b0, 1'b0, 1'b0, 2'b00},
    {9'h13C, 1'b1, 1'b0, 1'b0, 2'b10},
    {9'h0F3, 1'b0, 1'b1, 1'b0, 2'b01},
    {9'h055, 1'b0, 1'b1, 1'b1, 2'b11},
    {9'h1FF, 1'b1, 1'b1, 1'b0, 2'b00},
    {9'h0AB, 1'b1, 1'b1, 1'b1, 2'b01},
    {9'h000, 1'b0, 1'b0, 1'b0, 2'b11},
    {9'h101, 1'b0, 1'b0, 1'b0, 2'b10}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_word(input logic [8:0] d, input bit lw, input bit pe, input bit po);
    int nb = lw ? 9 : 8;
    int ones = 0;
    logic [8:0] w = '0;
    for (int i = 0; i < nb - 1; i++) begin
      w[i] = d[i];
      if (d[i]) ones++;
    end
    if (pe) w[nb-1] = ((ones % 2) == 1) ^ po;
    else    w[nb-1] = d[nb-1];
    return w;
  endfunction

  function automatic int exp_stop(input logic [1:0] c);
    case (c)
      2'b00:   return 16;
      2'b01:   return 8;
      2'b10:   return 32;
      default: return 24;
    endcase
  endfunction

  task automatic push(input logic [8:0] d);
    in_data  = d;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_start(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!txd) begin
        seen = 1'b1;
        return;
      end
    end
  endtask

  // entered at the first falling clock edge with the start bit on the line
  task automatic rx_frame(input int cpt, input int nb, input bit to_done,
                          output logic [8:0] got, output int stop_cnt, output bit start_ok);
    got = '0;
    repeat (8 * cpt) @(negedge clk);
    start_ok = !txd;
    for (int i = 0; i < nb; i++) begin
      repeat (16 * cpt) @(negedge clk);
      got[i] = txd;
    end
    repeat (8 * cpt) @(negedge clk);
    stop_cnt = 0;
    while (txd && !(to_done && tx_done) && stop_cnt < 2000) begin
      stop_cnt++;
      @(negedge clk);
    end
  endtask

  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (txd == lvl && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [8:0] g1, g2, e;
    int s1, s2, lowc, highc, c;
    bit seen, ok1, ok2, lowseen;
    logic [13:0] v;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(txd && in_ready && tx_done, "R1 in reset", {txd, in_ready, tx_done}, 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd && in_ready && tx_done, "R1 after reset", {txd, in_ready, tx_done}, 7);

    // vector table: two identical words back to back per entry (R2 R3 R4 R5 R6 R7)
    for (int k = 0; k < 8; k++) begin
      v = VECS[k];
      cfg_long_word  = v[4];
      cfg_parity_en  = v[3];
      cfg_parity_odd = v[2];
      cfg_stop       = v[1:0];
      e = exp_word(v[13:5], v[4], v[3], v[2]);
      push(v[13:5]);
      fork
        push(v[13:5]);
        begin
          wait_start(seen);
          rx_frame(1, v[4] ? 9 : 8, 1'b0, g1, s1, ok1);
          rx_frame(1, v[4] ? 9 : 8, 1'b1, g2, s2, ok2);
        end
      join
      chk(seen && ok1, "R2 start bit frame 1", ok1, 1);
      chk(g1 == e, "R3/R4 data frame 1", g1, e);
      chk(s1 == exp_stop(v[1:0]), "R5/R6 gap before buffered word", s1, exp_stop(v[1:0]));
      chk(ok2 && g2 == e, "R4 data frame 2", g2, e);
      chk(s2 == exp_stop(v[1:0]), "R5/R7 stop until done", s2, exp_stop(v[1:0]));
    end

    // R6: offered word while buffer full is ignored
    cfg_long_word = 1'b0; cfg_parity_en = 1'b0; cfg_parity_odd = 1'b0; cfg_stop = 2'b00;
    push(9'h03C);
    fork
      begin
        push(9'h0C5);
        chk(!in_ready, "R6 ready low while buffer full", in_ready, 0);
        in_data  = 9'h1E7;
        in_valid = 1'b1;
        repeat (20) @(negedge clk);
        in_valid = 1'b0;
      end
      begin
        wait_start(seen);
        rx_frame(1, 8, 1'b0, g1, s1, ok1);
        rx_frame(1, 8, 1'b1, g2, s2, ok2);
      end
    join
    chk(g1 == 9'h03C && g2 == 9'h0C5, "R6 two accepted words sent", {g1, g2}, {9'h03C, 9'h0C5});
    lowseen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (!txd || !tx_done) lowseen = 1'b1;
      @(negedge clk);
    end
    chk(!lowseen, "R6 rejected word never sent", lowseen, 0);

    // R8: idle frame, short word, half stop
    cfg_stop = 2'b01;
    idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    c = 0; lowseen = 1'b0;
    while (!tx_done && c < 2000) begin
      if (!txd) lowseen = 1'b1;
      c++;
      @(negedge clk);
    end
    chk(c == 153, "R8 idle frame length", c, 153);
    chk(!lowseen, "R8 idle frame line high", lowseen, 0);

    // R9: break frame, long word, two stop bits
    cfg_long_word = 1'b1; cfg_stop = 2'b10;
    break_req = 1'b1;
    @(negedge clk);
    break_req = 1'b0;
    wait_start(seen);
    count_level(1'b0, lowc);
    chk(lowc == 160, "R9 break low time", lowc, 160);
    c = 0;
    while (!tx_done && txd && c < 2000) begin
      c++;
      @(negedge clk);
    end
    chk(c == 32 && txd, "R9 break stop time", c, 32);

    // R10: break, then idle, then buffered word
    cfg_long_word = 1'b0; cfg_stop = 2'b00;
    push(9'h0E1);
    fork
      begin
        push(9'h05A);
        idle_req = 1'b1;
        @(negedge clk);
        idle_req = 1'b0;
        break_req = 1'b1;
        @(negedge clk);
        break_req = 1'b0;
      end
      begin
        wait_start(seen);
        rx_frame(1, 8, 1'b0, g1, s1, ok1);
        count_level(1'b0, lowc);
        count_level(1'b1, highc);
        rx_frame(1, 8, 1'b1, g2, s2, ok2);
      end
    join
    chk(g1 == 9'h0E1, "R10 first word", g1, 9'h0E1);
    chk(lowc == 144, "R10 break goes next", lowc, 144);
    chk(highc == 176, "R10 idle after break", highc, 176);
    chk(ok2 && g2 == 9'h05A, "R10 buffered word last", g2, 9'h05A);

    // R2: divider of three stretches bit time to 48 cycles
    cfg_div = 16'd3;
    push(9'h096);
    wait_start(seen);
    rx_frame(3, 8, 1'b1, g1, s1, ok1);
    chk(ok1 && g1 == 9'h096, "R2 data with divider 3", g1, 9'h096);
    chk(s1 == 48, "R2 stop cycles with divider 3", s1, 48);
    cfg_div = 16'd1;

    // R11: configuration changed mid frame; R7 done low with word buffered
    push(9'h1C3);
    chk(!tx_done, "R7 done low after accept", tx_done, 0);
    wait_start(seen);
    cfg_long_word = 1'b1; cfg_parity_en = 1'b1; cfg_parity_odd = 1'b1; cfg_stop = 2'b10;
    rx_frame(1, 8, 1'b1, g1, s1, ok1);
    chk(g1 == 9'h0C3, "R11 data keeps start config", g1, 9'h0C3);
    chk(s1 == 16, "R11 stop keeps start config", s1, 16);
    chk(tx_done && txd, "R7 done high when empty", {tx_done, txd}, 3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule